// File: doc/BRIEF.md
# Per-Level Paging Control and Fault Status Registers

This block stores one paging control word for each interrupt level, and it holds the three status registers that software reads after a memory fault. A control word is written through a single data word. That word carries both the value and, in a small field, the level it belongs to. Only the bits that the paging hardware uses are kept. A control-word read names its level the same way, through a field in an operand word.

The translation unit reports paging faults on one capture port. The memory range checker reports out-of-range physical accesses on another. Each kind of report is captured only if its register set is free. After a capture the set locks and keeps the first error until software reads the register that releases it. The block has one disable input that blocks control-word writes. Signalling the resulting interrupt is handled outside this block.

Top module: `paging_ctl_regs`

## Requirements
- R1: After reset every control word reads as zero, the three status registers read as zero, and both capture locks are released.
- R2: On a write (`wr_en`=1), the level index is taken from `wr_data[6:3]`. The stored word is `wr_data & 16'h0783`, which keeps bits 10:7 and 1:0. Bits 15:11 and 6:2 always read back as zero.
- R3: A read with `rd_sel`=0 returns the control word of the level given by `rd_operand[6:3]`. Each of the sixteen levels is independent.
- R4: Every read has a latency of one clock. `rd_valid`, `rd_data` and `rd_illegal` change at the clock edge that samples `rd_en`=1, and `rd_valid` is low in any cycle that follows a cycle without a read.
- R5: An out-of-range report (`mor_valid`=1) that arrives while the error set is unlocked has three effects. The error address register (`rd_sel`=1) gets `mor_addr[15:0]`. The error status register (`rd_sel`=2) gets `{mor_dma, mor_fetch, 6'b0, mor_addr[23:16]}`, so the DMA flag is bit 15, the fetch flag is bit 14 and the upper address bits sit in bits 7:0. The error set then locks.
- R6: While the error set is locked, further out-of-range reports change neither register.
- R7: Reading the error address register releases the error set lock. Reading the error status register does not.
- R8: A paging fault report (`pf_valid`=1) that arrives while the paging status register (`rd_sel`=3) is unlocked stores `{pf_flags[7:0], pf_table[1:0], pf_page[5:0]}` and locks it. Reports are ignored while it is locked. Reading the register releases the lock.
- R9: While `mm_disable`=1, control-word writes leave every control word unchanged.
- R10: A read with `rd_sel` from 4 to 7 returns `rd_illegal`=1 with `rd_data`=0. Legal selects return `rd_illegal`=0.
- R11: If a capture and a releasing read of the same unlocked register happen in the same cycle, the read returns the value held before the capture, the new value is stored, and the register ends up locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mm_disable | input | 1 | Blocks control-word writes |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Write word: value bits plus level index in 6:3 |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 3 | Register select: 0 control word, 1 error address, 2 error status, 3 paging status |
| rd_operand | input | 16 | Level index in bits 6:3 for control-word reads |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_data | output | 16 | Read result |
| rd_illegal | output | 1 | Read used an unknown select code |
| mor_valid | input | 1 | Out-of-range report strobe |
| mor_addr | input | 24 | Physical address of the failing access |
| mor_dma | input | 1 | Failing access came from DMA |
| mor_fetch | input | 1 | Failing access was an instruction fetch |
| pf_valid | input | 1 | Paging fault report strobe |
| pf_table | input | 2 | Page table number of the fault |
| pf_page | input | 6 | Virtual page number of the fault |
| pf_flags | input | 8 | Fault kind flags |

## Verification
Some internal faults are visible at the next read of the affected register. A lock that fails to set lets a second error overwrite the first, so the register shows the wrong address or record on that read. A lock that fails to release makes the register keep an old error after software has acknowledged it, and this shows on the first read after the next error. A wrong write mask or a wrong level decode shows as a wrong value one cycle after the control-word read of that level. Reading one control word after a write to another shows whether the levels alias.

// File: rtl/paging_ctl_pkg.sv
package paging_ctl_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CW    = 3'd0;
  localparam logic [SEL_W-1:0] SEL_EADDR = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ESTAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PSTAT = 3'd3;
endpackage

// File: rtl/pcw_bank.sv
// Per-level control word storage with masked write and registered read.
module pcw_bank #(
  parameter int DATA_W  = 16,
  parameter int LVL_W   = 4,
  parameter int LVL_LSB = 3,
  parameter logic [DATA_W-1:0] WR_MASK = 16'h0783
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [LVL_W-1:0]  ridx,
  output logic [DATA_W-1:0] rq
);
  localparam int NUM_LVL = 1 << LVL_W;

  logic [DATA_W-1:0] words [NUM_LVL];
  logic [LVL_W-1:0]  widx;

  assign widx = wdata[LVL_LSB +: LVL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LVL; i++) words[i] <= '0;
    end else if (we) begin
      words[widx] <= wdata & WR_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rq <= '0;
    else if (re) rq <= words[ridx];
  end
endmodule

// File: rtl/first_err_latch.sv
// Captures a word only while unlocked, then holds it until released.
module first_err_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] cap_d,
  input  logic         release_i,
  output logic [W-1:0] q,
  output logic         locked
);
  logic take;
  assign take = cap && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      locked <= 1'b0;
    end else begin
      if (take) q <= cap_d;
      if (take)           locked <= 1'b1;
      else if (release_i) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/paging_ctl_regs.sv
module paging_ctl_regs #(
  parameter int DATA_W  = 16,
  parameter int LVL_W   = 4,
  parameter int LVL_LSB = 3,
  parameter logic [DATA_W-1:0] WR_MASK = 16'h0783,
  parameter int PADDR_W = 24,
  parameter int PT_W    = 2,
  parameter int PG_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mm_disable,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  input  logic [paging_ctl_pkg::SEL_W-1:0] rd_sel,
  input  logic [DATA_W-1:0]             rd_operand,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_illegal,
  input  logic                          mor_valid,
  input  logic [PADDR_W-1:0]            mor_addr,
  input  logic                          mor_dma,
  input  logic                          mor_fetch,
  input  logic                          pf_valid,
  input  logic [PT_W-1:0]               pf_table,
  input  logic [PG_W-1:0]               pf_page,
  input  logic [DATA_W-PT_W-PG_W-1:0]   pf_flags
);
  import paging_ctl_pkg::*;

  localparam int HI_W  = PADDR_W - DATA_W;
  localparam int PAD_W = DATA_W - 2 - HI_W;

  // Control word bank
  logic              cw_we, cw_re;
  logic [DATA_W-1:0] cw_q;
  assign cw_we = wr_en && !mm_disable;
  assign cw_re = rd_en && (rd_sel == SEL_CW);

  pcw_bank #(
    .DATA_W(DATA_W), .LVL_W(LVL_W), .LVL_LSB(LVL_LSB), .WR_MASK(WR_MASK)
  ) u_bank (
    .clk(clk), .rst(rst), .we(cw_we), .wdata(wr_data),
    .re(cw_re), .ridx(rd_operand[LVL_LSB +: LVL_W]), .rq(cw_q)
  );

  // Error address and status share one lock, released by the address read
  logic [2*DATA_W-1:0] ea_cap_d, ea_word;
  logic                ea_lock;
  logic [DATA_W-1:0]   estat_d;
  assign estat_d  = {mor_dma, mor_fetch, {PAD_W{1'b0}}, mor_addr[PADDR_W-1:DATA_W]};
  assign ea_cap_d = {estat_d, mor_addr[DATA_W-1:0]};

  first_err_latch #(.W(2*DATA_W)) u_err (
    .clk(clk), .rst(rst), .cap(mor_valid), .cap_d(ea_cap_d),
    .release_i(rd_en && (rd_sel == SEL_EADDR)),
    .q(ea_word), .locked(ea_lock)
  );

  // Paging fault status
  logic [DATA_W-1:0] ps_word;
  logic              ps_lock;
  first_err_latch #(.W(DATA_W)) u_pf (
    .clk(clk), .rst(rst), .cap(pf_valid), .cap_d({pf_flags, pf_table, pf_page}),
    .release_i(rd_en && (rd_sel == SEL_PSTAT)),
    .q(ps_word), .locked(ps_lock)
  );

  // Registered read path
  logic              sel_cw_q;
  logic [DATA_W-1:0] aux_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_illegal <= 1'b0;
      sel_cw_q   <= 1'b0;
      aux_q      <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_cw_q   <= (rd_sel == SEL_CW);
        rd_illegal <= 1'b0;
        aux_q      <= '0;
        unique case (rd_sel)
          SEL_CW:    ;
          SEL_EADDR: aux_q <= ea_word[DATA_W-1:0];
          SEL_ESTAT: aux_q <= ea_word[2*DATA_W-1:DATA_W];
          SEL_PSTAT: aux_q <= ps_word;
          default:   rd_illegal <= 1'b1;
        endcase
      end
    end
  end

  assign rd_data = sel_cw_q ? cw_q : aux_q;
endmodule

// File: rtl/paging_ctl_chk.sv
module paging_ctl_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic [2:0]          rd_sel,
  input logic                rd_valid,
  input logic [DATA_W-1:0]   rd_data,
  input logic                rd_illegal,
  input logic                mor_valid,
  input logic                pf_valid,
  input logic                ea_lock,
  input logic                ps_lock,
  input logic [2*DATA_W-1:0] ea_word,
  input logic [DATA_W-1:0]   ps_word
);
  // R4
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);
  // R4
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid);
  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst) rd_illegal |-> rd_data == '0);
  // R10
  illegal_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sel > 3'd3) |=> rd_illegal);
  // R5
  ea_lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mor_valid && !ea_lock) |=> ea_lock);
  // R6
  ea_hold_chk: assert property (@(posedge clk) disable iff (rst) ea_lock |=> $stable(ea_word));
  // R7
  stat_keeps_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (ea_lock && rd_en && rd_sel == 3'd2) |=> ea_lock);
  // R8
  ps_lock_set_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !ps_lock) |=> ps_lock);
  // R8
  ps_hold_chk: assert property (@(posedge clk) disable iff (rst) ps_lock |=> $stable(ps_word));
endmodule

bind paging_ctl_regs paging_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_illegal(rd_illegal), .mor_valid(mor_valid),
  .pf_valid(pf_valid), .ea_lock(ea_lock), .ps_lock(ps_lock),
  .ea_word(ea_word), .ps_word(ps_word)
);

// File: tb/tb_paging_ctl_regs.sv
module tb_paging_ctl_regs;
  logic        clk = 0;
  logic        rst = 1;
  logic        mm_disable = 0;
  logic        wr_en = 0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_operand = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        rd_illegal;
  logic        mor_valid = 0;
  logic [23:0] mor_addr = '0;
  logic        mor_dma = 0;
  logic        mor_fetch = 0;
  logic        pf_valid = 0;
  logic [1:0]  pf_table = '0;
  logic [5:0]  pf_page = '0;
  logic [7:0]  pf_flags = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  paging_ctl_regs dut (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] sel, logic [3:0] lvl, output logic [15:0] d,
                    output logic ill, output logic v);
    @(negedge clk);
    rd_en = 1; rd_sel = sel; rd_operand = {9'd0, lvl, 3'd0};
    @(negedge clk);
    rd_en = 0;
    d = rd_data; ill = rd_illegal; v = rd_valid;
  endtask

  task automatic wr(logic [15:0] w);
    @(negedge clk);
    wr_en = 1; wr_data = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic mor(logic [23:0] a, logic dma, logic fetch);
    @(negedge clk);
    mor_valid = 1; mor_addr = a; mor_dma = dma; mor_fetch = fetch;
    @(negedge clk);
    mor_valid = 0;
  endtask

  task automatic pf(logic [1:0] t, logic [5:0] p, logic [7:0] f);
    @(negedge clk);
    pf_valid = 1; pf_table = t; pf_page = p; pf_flags = f;
    @(negedge clk);
    pf_valid = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic ill, v;
    rd(3'd0, 4'd7, d, ill, v);  chk("R1 cw", d, 16'h0000);
    rd(3'd1, 4'd0, d, ill, v);  chk("R1 eaddr", d, 16'h0000);
    rd(3'd2, 4'd0, d, ill, v);  chk("R1 estat", d, 16'h0000);
    rd(3'd3, 4'd0, d, ill, v);  chk("R1 pstat", d, 16'h0000);
    chk("R4 valid", {15'd0, v}, 16'd1);
    @(negedge clk);
    chk("R4 idle", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_cw();
    logic [15:0] d; logic ill, v;
    wr(16'hFFFF);
    wr(16'h0281 | (16'd5 << 3));
    wr(16'hF87F & ~(16'hF << 3) | (16'd2 << 3));
    rd(3'd0, 4'd15, d, ill, v); chk("R2 mask lvl15", d, 16'h0783);
    rd(3'd0, 4'd5, d, ill, v);  chk("R3 lvl5", d, 16'h0281);
    rd(3'd0, 4'd2, d, ill, v);  chk("R2 lvl2", d, 16'h0003);
    chk("R10 legal", {15'd0, ill}, 16'd0);
    rd(3'd0, 4'd4, d, ill, v);  chk("R3 untouched lvl4", d, 16'h0000);
  endtask

  task automatic t_disable();
    logic [15:0] d; logic ill, v;
    wr(16'h0101 | (16'd3 << 3));
    mm_disable = 1;
    wr(16'h0783 | (16'd3 << 3));
    mm_disable = 0;
    rd(3'd0, 4'd3, d, ill, v);  chk("R9 disabled write", d, 16'h0101);
  endtask

  task automatic t_mor();
    logic [15:0] d; logic ill, v;
    mor(24'hAB1234, 1'b1, 1'b0);
    rd(3'd2, 4'd0, d, ill, v);  chk("R5 estat", d, 16'h80AB);
    mor(24'h0F5555, 1'b0, 1'b1);
    rd(3'd2, 4'd0, d, ill, v);  chk("R6/R7 estat held", d, 16'h80AB);
    rd(3'd1, 4'd0, d, ill, v);  chk("R6 eaddr held", d, 16'h1234);
    mor(24'h0F5555, 1'b0, 1'b1);
    rd(3'd1, 4'd0, d, ill, v);  chk("R7 eaddr after release", d, 16'h5555);
    rd(3'd2, 4'd0, d, ill, v);  chk("R5 estat fetch", d, 16'h400F);
  endtask

  task automatic t_collide();
    logic [15:0] d; logic ill, v;
    @(negedge clk);
    mor_valid = 1; mor_addr = 24'h000777; mor_dma = 0; mor_fetch = 0;
    rd_en = 1; rd_sel = 3'd1;
    @(negedge clk);
    mor_valid = 0; rd_en = 0;
    chk("R11 old value", rd_data, 16'h5555);
    mor(24'h000111, 1'b0, 1'b0);
    rd(3'd1, 4'd0, d, ill, v);  chk("R11 locked", d, 16'h0777);
  endtask

  task automatic t_pf();
    logic [15:0] d; logic ill, v;
    pf(2'd2, 6'h15, 8'h81);
    pf(2'd1, 6'h03, 8'h00);
    rd(3'd3, 4'd0, d, ill, v);  chk("R8 first fault", d, 16'h8195);
    pf(2'd1, 6'h03, 8'h00);
    rd(3'd3, 4'd0, d, ill, v);  chk("R8 after release", d, 16'h0043);
  endtask

  task automatic t_illegal();
    logic [15:0] d; logic ill, v;
    rd(3'd5, 4'd0, d, ill, v);
    chk("R10 flag", {15'd0, ill}, 16'd1);
    chk("R10 data", d, 16'h0000);
    rd(3'd7, 4'd15, d, ill, v);
    chk("R10 flag sel7", {15'd0, ill}, 16'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_cw();
    t_disable();
    t_mor();
    t_collide();
    t_pf();
    t_illegal();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule